// File: doc/BRIEF.md
# Microcoded Multicycle Instruction Sequencer

This block produces the datapath control word for a small multicycle load/store processor. Each control word comes from a microcode ROM, and a micro-address register selects the word. A next-action field in each word chooses the following micro-address. The choices are the next sequential word, a return to the instruction-fetch word, or a jump through one of two opcode-indexed jump tables. The program in the ROM covers instruction fetch, decode and register read, conditional branch on equality, register-register arithmetic, word load and word store.

The surrounding datapath supplies the 6-bit opcode held in its instruction register and the ALU zero flag. The block drives the PC, memory, instruction-register, register-file and ALU controls. It also gives a combined PC load enable that applies the zero flag to the conditional branch write. A small monitor counts the cycles each instruction spends between two fetches. When the sequencer returns to fetch, the monitor reports that count together with a one-cycle completion pulse.

Micro-addresses, which are also the states: FETCH (0), DECODE (1), MEM1 (2), LW2 (3), LW3 (4), SW2 (5), RT1 (6), RT2 (7), BEQ1 (8). The transitions are:
- FETCH to DECODE.
- DECODE through table 1: opcode 4 goes to BEQ1, opcode 0 to RT1, and opcodes 35 and 43 to MEM1. Any other opcode goes to FETCH.
- MEM1 through table 2: opcode 35 goes to LW2 and opcode 43 to SW2. Any other opcode goes to FETCH.
- LW2 to LW3, and RT1 to RT2.
- LW3, SW2, RT2 and BEQ1 each return to FETCH.

Top module: `ucode_seq`

## Requirements
- R1: After reset, and one cycle after every FETCH, the micro-address follows the defined sequence. Reset puts it at FETCH (0), and FETCH is always followed by DECODE (1).
- R2: In FETCH the outputs are: pc_upd=1, mem_addr_sel=0, mem_rd=1, mem_wr=0, ir_load=1, rf_wr=0, alu_a_reg=0, alu_b_sel=01, alu_op=010 and pc_from_reg=0. Every other output is 0.
- R3: In DECODE the outputs are alu_b_sel=11 and alu_op=010 (add), with no write enable active. The next address comes from jump table 1.
- R4: Jump table 1 maps opcode 4 to BEQ1 (8), opcode 0 to RT1 (6), and opcodes 35 and 43 to MEM1 (2).
- R5: Jump table 2 maps opcode 35 to LW2 (3) and opcode 43 to SW2 (5).
- R6: BEQ1 drives alu_a_reg=1, alu_b_sel=00, alu_op=110 (subtract), pc_upd_zero=1, pc_from_reg=1 and pc_upd=0. pc_load equals alu_zero in that state, and the next state is FETCH.
- R7: RT1 drives alu_a_reg=1, alu_b_sel=00 and alu_op=100 (function field). RT2 then drives rf_wr=1 with wr_dst_sel=1 and wb_from_mem=0, and returns to FETCH.
- R8: LW2 drives mem_rd=1 with mem_addr_sel=1. LW3 then drives rf_wr=1 with wr_dst_sel=0 and wb_from_mem=1, and returns to FETCH.
- R9: MEM1 drives alu_a_reg=1, alu_b_sel=10 and alu_op=010. SW2 then drives mem_wr=1 with mem_addr_sel=1 and rf_wr=0, and returns to FETCH.
- R10: In the FETCH cycle that follows a completed instruction, instr_done is 1 for exactly one cycle. instr_len then gives that instruction's cycle count: 3 for beq, 4 for R-type, 4 for sw and 5 for lw.
- R11: An opcode absent from table 1 returns to FETCH directly after DECODE (instr_len 2), and no write enable is asserted in between.
- R12: mem_rd and mem_wr are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 6 | Opcode field of the current instruction |
| alu_zero | input | 1 | ALU zero flag |
| pc_upd | output | 1 | Unconditional PC write |
| pc_upd_zero | output | 1 | PC write qualified by the zero flag |
| pc_load | output | 1 | Combined PC load enable |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register load |
| wr_dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wb_from_mem | output | 1 | Write-back data: 0 ALU output, 1 memory data register |
| rf_wr | output | 1 | Register file write |
| alu_a_reg | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 constant 4, 10 sign-extended, 11 sign-extended shifted |
| alu_op | output | 3 | 010 add, 110 subtract, 100 function field |
| pc_from_reg | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| uaddr | output | 4 | Current micro-address |
| instr_done | output | 1 | Pulse on return to fetch |
| instr_len | output | 4 | Cycle count of the last instruction |

## Verification
The second jump table is hard to reach. It is used only in MEM1, which needs a memory opcode to pass through table 1 first. The opcode must then stay stable for one more cycle so that table 2 picks the load or store branch. Each directed scenario holds the opcode from the fetch cycle until the return to fetch, and follows every micro-address and control word along the way. A reset in the middle of a load checks that the sequencer leaves a deep state and restarts at FETCH.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int UA_W = 4;

    typedef enum logic [UA_W-1:0] {
        UA_FETCH  = 4'd0,
        UA_DECODE = 4'd1,
        UA_MEM1   = 4'd2,
        UA_LW2    = 4'd3,
        UA_LW3    = 4'd4,
        UA_SW2    = 4'd5,
        UA_RT1    = 4'd6,
        UA_RT2    = 4'd7,
        UA_BEQ1   = 4'd8
    } uaddr_e;

    typedef enum logic [1:0] {
        NX_SEQ   = 2'd0,
        NX_FETCH = 2'd1,
        NX_JT1   = 2'd2,
        NX_JT2   = 2'd3
    } next_e;

    localparam logic [2:0] ALU_ADD  = 3'b010;
    localparam logic [2:0] ALU_SUB  = 3'b110;
    localparam logic [2:0] ALU_FUNC = 3'b100;

    localparam logic [1:0] BSRC_REG   = 2'b00;
    localparam logic [1:0] BSRC_FOUR  = 2'b01;
    localparam logic [1:0] BSRC_EXT   = 2'b10;
    localparam logic [1:0] BSRC_EXTSH = 2'b11;

    typedef struct packed {
        logic       pc_upd;
        logic       pc_upd_zero;
        logic       mem_addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_load;
        logic       wr_dst_sel;
        logic       wb_from_mem;
        logic       rf_wr;
        logic       alu_a_reg;
        logic [1:0] alu_b_sel;
        logic [2:0] alu_op;
        logic       pc_from_reg;
    } uctl_t;

    typedef struct packed {
        uctl_t ctl;
        next_e nxt;
    } uword_t;

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
    import ucode_pkg::*;
(
    input  uaddr_e ua,
    output uword_t uw
);

    always_comb begin
        uw = '0;
        uw.nxt = NX_FETCH;
        unique case (ua)
            UA_FETCH: begin
                uw.ctl.pc_upd    = 1'b1;
                uw.ctl.mem_rd    = 1'b1;
                uw.ctl.ir_load   = 1'b1;
                uw.ctl.alu_b_sel = BSRC_FOUR;
                uw.ctl.alu_op    = ALU_ADD;
                uw.nxt           = NX_SEQ;
            end
            UA_DECODE: begin
                uw.ctl.alu_b_sel = BSRC_EXTSH;
                uw.ctl.alu_op    = ALU_ADD;
                uw.nxt           = NX_JT1;
            end
            UA_MEM1: begin
                uw.ctl.alu_a_reg = 1'b1;
                uw.ctl.alu_b_sel = BSRC_EXT;
                uw.ctl.alu_op    = ALU_ADD;
                uw.nxt           = NX_JT2;
            end
            UA_LW2: begin
                uw.ctl.mem_addr_sel = 1'b1;
                uw.ctl.mem_rd       = 1'b1;
                uw.nxt              = NX_SEQ;
            end
            UA_LW3: begin
                uw.ctl.wb_from_mem = 1'b1;
                uw.ctl.rf_wr       = 1'b1;
                uw.nxt             = NX_FETCH;
            end
            UA_SW2: begin
                uw.ctl.mem_addr_sel = 1'b1;
                uw.ctl.mem_wr       = 1'b1;
                uw.nxt              = NX_FETCH;
            end
            UA_RT1: begin
                uw.ctl.alu_a_reg = 1'b1;
                uw.ctl.alu_b_sel = BSRC_REG;
                uw.ctl.alu_op    = ALU_FUNC;
                uw.nxt           = NX_SEQ;
            end
            UA_RT2: begin
                uw.ctl.wr_dst_sel = 1'b1;
                uw.ctl.rf_wr      = 1'b1;
                uw.nxt            = NX_FETCH;
            end
            UA_BEQ1: begin
                uw.ctl.alu_a_reg   = 1'b1;
                uw.ctl.alu_b_sel   = BSRC_REG;
                uw.ctl.alu_op      = ALU_SUB;
                uw.ctl.pc_upd_zero = 1'b1;
                uw.ctl.pc_from_reg = 1'b1;
                uw.nxt             = NX_FETCH;
            end
            default: begin
                uw.nxt = NX_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/ucode_jump.sv
module ucode_jump
    import ucode_pkg::*;
#(
    parameter int          OP_W   = 6,
    parameter logic [OP_W-1:0] OP_RTYPE = 6'd0,
    parameter logic [OP_W-1:0] OP_BEQ   = 6'd4,
    parameter logic [OP_W-1:0] OP_LW    = 6'd35,
    parameter logic [OP_W-1:0] OP_SW    = 6'd43
) (
    input  logic [OP_W-1:0] opcode,
    output uaddr_e          jt1_tgt,
    output uaddr_e          jt2_tgt
);

    always_comb begin
        unique case (opcode)
            OP_BEQ:        jt1_tgt = UA_BEQ1;
            OP_RTYPE:      jt1_tgt = UA_RT1;
            OP_LW, OP_SW:  jt1_tgt = UA_MEM1;
            default:       jt1_tgt = UA_FETCH;
        endcase
    end

    always_comb begin
        unique case (opcode)
            OP_LW:   jt2_tgt = UA_LW2;
            OP_SW:   jt2_tgt = UA_SW2;
            default: jt2_tgt = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/ucode_cycmon.sv
module ucode_cycmon #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_step,
    output logic             done,
    output logic [CNT_W-1:0] len
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_inc;

    assign run_inc = (run_cnt == CNT_MAX) ? CNT_MAX : run_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            len     <= '0;
            done    <= 1'b0;
        end else begin
            done <= last_step;
            if (last_step) begin
                run_cnt <= '0;
                len     <= run_inc;
            end else begin
                run_cnt <= run_inc;
            end
        end
    end

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (len >= 2));

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
#(
    parameter int OP_W  = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic             alu_zero,
    output logic             pc_upd,
    output logic             pc_upd_zero,
    output logic             pc_load,
    output logic             mem_addr_sel,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_load,
    output logic             wr_dst_sel,
    output logic             wb_from_mem,
    output logic             rf_wr,
    output logic             alu_a_reg,
    output logic [1:0]       alu_b_sel,
    output logic [2:0]       alu_op,
    output logic             pc_from_reg,
    output logic [UA_W-1:0]  uaddr,
    output logic             instr_done,
    output logic [CNT_W-1:0] instr_len
);

    localparam logic [OP_W-1:0] OP_RTYPE = OP_W'(0);
    localparam logic [OP_W-1:0] OP_BEQ   = OP_W'(4);
    localparam logic [OP_W-1:0] OP_LW    = OP_W'(35);
    localparam logic [OP_W-1:0] OP_SW    = OP_W'(43);

    uaddr_e upc;
    uaddr_e upc_nxt;
    uaddr_e jt1_tgt;
    uaddr_e jt2_tgt;
    uword_t uw;

    ucode_rom u_rom (
        .ua (upc),
        .uw (uw)
    );

    ucode_jump #(
        .OP_W     (OP_W),
        .OP_RTYPE (OP_RTYPE),
        .OP_BEQ   (OP_BEQ),
        .OP_LW    (OP_LW),
        .OP_SW    (OP_SW)
    ) u_jump (
        .opcode  (opcode),
        .jt1_tgt (jt1_tgt),
        .jt2_tgt (jt2_tgt)
    );

    // next-address selection
    always_comb begin
        unique case (uw.nxt)
            NX_SEQ:   upc_nxt = uaddr_e'(upc + 1'b1);
            NX_FETCH: upc_nxt = UA_FETCH;
            NX_JT1:   upc_nxt = jt1_tgt;
            NX_JT2:   upc_nxt = jt2_tgt;
            default:  upc_nxt = UA_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= UA_FETCH;
        else        upc <= upc_nxt;
    end

    // outputs
    always_comb begin
        pc_upd       = uw.ctl.pc_upd;
        pc_upd_zero  = uw.ctl.pc_upd_zero;
        pc_load      = uw.ctl.pc_upd | (uw.ctl.pc_upd_zero & alu_zero);
        mem_addr_sel = uw.ctl.mem_addr_sel;
        mem_rd       = uw.ctl.mem_rd;
        mem_wr       = uw.ctl.mem_wr;
        ir_load      = uw.ctl.ir_load;
        wr_dst_sel   = uw.ctl.wr_dst_sel;
        wb_from_mem  = uw.ctl.wb_from_mem;
        rf_wr        = uw.ctl.rf_wr;
        alu_a_reg    = uw.ctl.alu_a_reg;
        alu_b_sel    = uw.ctl.alu_b_sel;
        alu_op       = uw.ctl.alu_op;
        pc_from_reg  = uw.ctl.pc_from_reg;
        uaddr        = upc;
    end

    ucode_cycmon #(
        .CNT_W (CNT_W)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_step (upc_nxt == UA_FETCH),
        .done      (instr_done),
        .len       (instr_len)
    );

    // R1
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_FETCH) |=> (upc == UA_DECODE));

    // R4
    beq_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_DECODE && opcode == OP_BEQ) |=> (upc == UA_BEQ1));

    // R6
    cond_pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_upd_zero |-> (!pc_upd && pc_load == alu_zero));

    // R11
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == UA_DECODE && opcode != OP_BEQ && opcode != OP_RTYPE &&
         opcode != OP_LW && opcode != OP_SW) |=> (upc == UA_FETCH));

    // R12
    mem_rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/ucode_seq_test.sv
`timescale 1ns/1ps
module ucode_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic       alu_zero = 1'b0;
    logic       pc_upd, pc_upd_zero, pc_load, mem_addr_sel, mem_rd, mem_wr;
    logic       ir_load, wr_dst_sel, wb_from_mem, rf_wr, alu_a_reg, pc_from_reg;
    logic [1:0] alu_b_sel;
    logic [2:0] alu_op;
    logic [3:0] uaddr;
    logic       instr_done;
    logic [3:0] instr_len;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ucode_seq uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .pc_upd(pc_upd), .pc_upd_zero(pc_upd_zero), .pc_load(pc_load),
        .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_load(ir_load), .wr_dst_sel(wr_dst_sel), .wb_from_mem(wb_from_mem),
        .rf_wr(rf_wr), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .pc_from_reg(pc_from_reg), .uaddr(uaddr),
        .instr_done(instr_done), .instr_len(instr_len)
    );

    // expected control words, bit order pc_upd .. pc_from_reg
    localparam logic [15:0] W_FETCH = 16'h9414;
    localparam logic [15:0] W_DEC   = 16'h0034;
    localparam logic [15:0] W_BEQ1  = 16'h404D;
    localparam logic [15:0] W_RT1   = 16'h0048;
    localparam logic [15:0] W_RT2   = 16'h0280;
    localparam logic [15:0] W_MEM1  = 16'h0064;
    localparam logic [15:0] W_SW2   = 16'h2800;
    localparam logic [15:0] W_LW2   = 16'h3000;
    localparam logic [15:0] W_LW3   = 16'h0180;

    function automatic logic [15:0] ctl_word();
        return {pc_upd, pc_upd_zero, mem_addr_sel, mem_rd, mem_wr, ir_load,
                wr_dst_sel, wb_from_mem, rf_wr, alu_a_reg, alu_b_sel, alu_op,
                pc_from_reg};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // at a negedge: check micro-address, word, pc_load; then advance one cycle
    task automatic step(string req, logic [3:0] ua, logic [15:0] w, logic ld);
        chk({req, " uaddr"}, 32'(uaddr), 32'(ua));
        chk({req, " ctl"}, 32'(ctl_word()), 32'(w));
        chk({req, " pc_load"}, 32'(pc_load), 32'(ld));
        if (mem_rd && mem_wr) chk("R12 rd/wr overlap", 1, 0);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic finish_chk(string req, int n);
        chk({req, " done"}, 32'(instr_done), 1);
        chk({req, " len"}, 32'(instr_len), 32'(n));
        chk({req, " back at fetch"}, 32'(uaddr), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 reset uaddr", 32'(uaddr), 0);
        chk("R2 reset fetch word", 32'(ctl_word()), 32'(W_FETCH));
        chk("R10 reset done", 32'(instr_done), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_beq(logic z);
        opcode = 6'd4; alu_zero = z;
        step("R2 beq fetch", 4'd0, W_FETCH, 1'b1);
        step("R3 beq decode", 4'd1, W_DEC, 1'b0);
        step("R6 BEQ1", 4'd8, W_BEQ1, z);
        finish_chk("R10 beq", 3);
    endtask

    task automatic t_rtype();
        opcode = 6'd0; alu_zero = 1'b1;
        step("R2 rtype fetch", 4'd0, W_FETCH, 1'b1);
        step("R3 rtype decode", 4'd1, W_DEC, 1'b0);
        step("R7 RT1", 4'd6, W_RT1, 1'b0);
        step("R7 RT2", 4'd7, W_RT2, 1'b0);
        finish_chk("R10 rtype", 4);
    endtask

    task automatic t_sw();
        opcode = 6'd43; alu_zero = 1'b0;
        step("R2 sw fetch", 4'd0, W_FETCH, 1'b1);
        step("R4 sw decode", 4'd1, W_DEC, 1'b0);
        step("R9 sw MEM1", 4'd2, W_MEM1, 1'b0);
        step("R5 R9 SW2", 4'd5, W_SW2, 1'b0);
        finish_chk("R10 sw", 4);
    endtask

    task automatic t_lw();
        opcode = 6'd35; alu_zero = 1'b1;
        step("R2 lw fetch", 4'd0, W_FETCH, 1'b1);
        step("R4 lw decode", 4'd1, W_DEC, 1'b0);
        step("R9 lw MEM1", 4'd2, W_MEM1, 1'b0);
        step("R5 R8 LW2", 4'd3, W_LW2, 1'b0);
        step("R8 LW3", 4'd4, W_LW3, 1'b0);
        finish_chk("R10 lw", 5);
    endtask

    task automatic t_unknown(logic [5:0] op);
        opcode = op;
        step("R11 unk fetch", 4'd0, W_FETCH, 1'b1);
        step("R11 unk decode", 4'd1, W_DEC, 1'b0);
        finish_chk("R11 unk", 2);
    endtask

    task automatic t_mid_reset();
        opcode = 6'd35;
        step("R1 mr fetch", 4'd0, W_FETCH, 1'b1);
        step("R1 mr decode", 4'd1, W_DEC, 1'b0);
        step("R1 mr MEM1", 4'd2, W_MEM1, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid reset uaddr", 32'(uaddr), 0);
        chk("R10 mid reset done", 32'(instr_done), 0);
        step("R1 after reset fetch", 4'd0, W_FETCH, 1'b1);
        chk("R1 after reset decode", 32'(uaddr), 1);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_beq(1'b1);
        t_beq(1'b0);
        t_rtype();
        t_sw();
        t_lw();
        t_unknown(6'd2);
        t_unknown(6'd63);
        t_lw();
        t_mid_reset();
        t_reset();
        t_sw();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule